// File: doc/BRIEF.md
# Cartridge Window Control and Address Decoder

This block sits between a console's parallel cartridge bus and the memories behind it. It holds a six-bit control register that says which memory windows the console may reach. Each bus address presented to it is decoded into a one-hot select for one of five regions: flash, SDRAM, parallel-bus EEPROM, debug transmit FIFO and debug receive FIFO. An address that no enabled window claims raises an unmapped flag. The read-data path that returns zero for unmapped reads lives outside this block and keys off that flag.

A console reset or NMI event takes priority over software. On the first clock edge at which the event input is high, flash is switched on and SDRAM and parallel EEPROM are switched off. A two-state machine tracks the event. ST_IDLE moves to ST_HELD on the edge where the event input is high; this is the entry transition and it applies the side effects. ST_HELD moves back to ST_IDLE on the first edge where the event input is low; this is the release transition. While the machine is in ST_HELD, and on the release edge itself, software cannot change the three event-controlled bits.

The flash window moves with the SDRAM enable. With SDRAM off, flash is based at 0x1000_0000. With SDRAM on, SDRAM takes 0x1000_0000 and flash moves up to 0x1800_0000. The window sizes are parameters, and the decode priority resolves any overlap that a parameter choice creates.

Top module: `cart_map_top`

## Requirements
- R1: After reset, reg_rdata reads 0x0000_0001. Bits 31:6 of reg_rdata always read zero. The register bits are: 0 flash enable, 1 SDRAM enable, 2 parallel EEPROM enable, 3 serial EEPROM enable, 4 EEPROM 16k ID, 5 debug FIFO enable.
- R2: Outside an event, a cycle with reg_we high loads reg_wdata[5:0] into the register. The new value is visible on reg_rdata after that clock edge. reg_wdata[31:6] is ignored.
- R3: On the clock edge where console_evt is first high (ST_IDLE to ST_HELD), bit 0 becomes 1 and bits 1 and 2 become 0. Bits 5:3 keep their value, or take reg_wdata[5:3] if a write happens in the same cycle.
- R4: From the entry edge through the first edge at which console_evt is low (ST_HELD to ST_IDLE), writes to bits 2:0 are ignored. Writes to bits 5:3 still take effect. After the release edge, all six bits are writable again.
- R5: With bit 1 set, a valid access with address in [0x1000_0000, 0x1000_0000 + 2^SDRAM_LOG2) selects SDRAM (region_sel[1]). The default SDRAM_LOG2 is 26.
- R6: With bit 0 set, a valid access in the 16 MB flash window selects flash (region_sel[0]). The window is based at 0x1000_0000 when bit 1 is 0, and at 0x1800_0000 when bit 1 is 1.
- R7: With bit 2 set, any valid access in [0x1D00_0000, 0x1D00_0800) selects the EEPROM (region_sel[2]). With bit 2 clear, that window does not select the EEPROM.
- R8: With bit 5 set, a valid 32-bit write (bus_word=1) with bus_addr[1:0]=0 in [0x1D10_0800, 0x1D10_0C00) selects the debug TX FIFO (region_sel[3]). Reads, narrow accesses and unaligned accesses there do not select it.
- R9: With bit 5 set, a valid 32-bit aligned read in [0x1D10_0000, 0x1D10_0400) selects the debug RX FIFO (region_sel[4]). Writes, narrow accesses and unaligned accesses there do not select it.
- R10: When bus_valid is high, exactly one of region_sel and unmapped is high, and unmapped is high only when no enabled window claims the access. When bus_valid is low, all of them are low. The decode is combinational and valid in the same cycle.
- R11: When windows overlap, the winner is picked in this order: debug RX, debug TX, EEPROM, SDRAM, flash. In particular, SDRAM wins over flash.
- R12: eep_serial_en equals bit 3 and eep_id16k equals bit 4 (1 = 16k ID, 0 = 4k ID), both visible after the edge that loads the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register contents, zero-extended |
| console_evt | input | 1 | Console reset/NMI event level, synchronous to clk |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = narrower access |
| bus_addr | input | 32 | Bus byte address |
| region_sel | output | 5 | One-hot select: 0 flash, 1 SDRAM, 2 EEPROM, 3 debug TX, 4 debug RX |
| unmapped | output | 1 | Valid access matched no enabled window |
| eep_serial_en | output | 1 | EEPROM serial-bus access enable |
| eep_id16k | output | 1 | EEPROM ID select, 1 = 16k, 0 = 4k |

## Verification
The region selects and the unmapped flag are combinational, so they are due in the same cycle as the address. The bench drives the address on the falling edge and samples 2 ns later, before the next rising edge. Register writes and event side effects each pass through one register. The bench drives them on a falling edge and reads reg_rdata and the EEPROM outputs at the next falling edge, after exactly one rising edge. The release-edge write is placed in the same cycle as the falling event input, so that the one-edge lock window is observed directly.

// File: rtl/cart_pkg.sv
package cart_pkg;

    localparam int CTL_W = 6;
    localparam int NREG  = 5;

    // region select bit positions; a higher index wins in the decoder
    localparam int RG_FLASH = 0;
    localparam int RG_SDRAM = 1;
    localparam int RG_EEP   = 2;
    localparam int RG_DTX   = 3;
    localparam int RG_DRX   = 4;

    typedef struct packed {
        logic dbg_en;
        logic eep_big;
        logic eep_ser_en;
        logic eep_par_en;
        logic sdram_en;
        logic flash_en;
    } cart_ctl_t;

    localparam logic [CTL_W-1:0] CTL_INIT = 6'h01;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } evt_st_e;

endpackage

// File: rtl/cart_win_match.sv
module cart_win_match #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE      = '0,
    parameter int                SPAN_LOG2 = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << SPAN_LOG2) - ADDR_W'(1));

    always_comb begin
        hit = (((addr ^ BASE) & HI_MASK) == '0);
    end

endmodule

// File: rtl/cart_ctrl_reg.sv
module cart_ctrl_reg
    import cart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [CTL_W-1:0] reg_wbits,
    input  logic             console_evt,
    output cart_ctl_t        ctl
);

    evt_st_e   st_q, st_d;
    cart_ctl_t ctl_q, ctl_d;
    logic      lock;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (console_evt)  st_d = ST_HELD;
            ST_HELD: if (!console_evt) st_d = ST_IDLE;
        endcase
    end

    // the lock covers the entry edge and every edge spent in ST_HELD
    always_comb begin
        lock = (st_q == ST_HELD) || ((st_q == ST_IDLE) && console_evt);
    end

    always_comb begin
        ctl_d = ctl_q;
        if (reg_we) begin
            ctl_d = cart_ctl_t'(reg_wbits);
        end
        if (lock) begin
            ctl_d.flash_en   = 1'b1;
            ctl_d.sdram_en   = 1'b0;
            ctl_d.eep_par_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= cart_ctl_t'(CTL_INIT);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

    // R3: the entry edge forces flash on, SDRAM and parallel EEPROM off
    a_r3_entry_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && console_evt) |=> (ctl_q.flash_en && !ctl_q.sdram_en && !ctl_q.eep_par_en));

    // R4: the event-controlled bits stay locked while the event is held
    a_r4_held_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD) |-> (ctl_q.flash_en && !ctl_q.sdram_en && !ctl_q.eep_par_en));

    // R4: the upper bits are still writable while locked
    a_r4_upper_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && reg_we) |=> ({ctl_q.dbg_en, ctl_q.eep_big, ctl_q.eep_ser_en} == $past(reg_wbits[5:3])));

    // R2: an unlocked write lands whole
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !console_evt && reg_we) |=> (ctl_q == cart_ctl_t'($past(reg_wbits))));

endmodule

// File: rtl/cart_decode.sv
module cart_decode
    import cart_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] SDRAM_BASE    = 32'h1000_0000,
    parameter int                SDRAM_LOG2    = 26,
    parameter logic [ADDR_W-1:0] FLASH_LO_BASE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] FLASH_HI_BASE = 32'h1800_0000,
    parameter int                FLASH_LOG2    = 24,
    parameter logic [ADDR_W-1:0] EEP_BASE      = 32'h1D00_0000,
    parameter int                EEP_LOG2      = 11,
    parameter logic [ADDR_W-1:0] DRX_BASE      = 32'h1D10_0000,
    parameter logic [ADDR_W-1:0] DTX_BASE      = 32'h1D10_0800,
    parameter int                FIFO_LOG2     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cart_ctl_t         ctl,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   region_sel,
    output logic              unmapped
);

    logic            hit_sd, hit_eep, hit_drx, hit_dtx;
    logic [1:0]      hit_fl;
    logic            aligned;
    logic [NREG-1:0] cand;
    logic            found;

    cart_win_match #(.ADDR_W(ADDR_W), .BASE(SDRAM_BASE), .SPAN_LOG2(SDRAM_LOG2))
        u_sd  (.addr(bus_addr), .hit(hit_sd));
    cart_win_match #(.ADDR_W(ADDR_W), .BASE(EEP_BASE),   .SPAN_LOG2(EEP_LOG2))
        u_eep (.addr(bus_addr), .hit(hit_eep));
    cart_win_match #(.ADDR_W(ADDR_W), .BASE(DRX_BASE),   .SPAN_LOG2(FIFO_LOG2))
        u_drx (.addr(bus_addr), .hit(hit_drx));
    cart_win_match #(.ADDR_W(ADDR_W), .BASE(DTX_BASE),   .SPAN_LOG2(FIFO_LOG2))
        u_dtx (.addr(bus_addr), .hit(hit_dtx));

    // one matcher per flash base; the SDRAM enable picks which one counts
    for (genvar g = 0; g < 2; g++) begin : g_flash
        cart_win_match #(
            .ADDR_W   (ADDR_W),
            .BASE     ((g == 0) ? FLASH_LO_BASE : FLASH_HI_BASE),
            .SPAN_LOG2(FLASH_LOG2)
        ) u_fl (.addr(bus_addr), .hit(hit_fl[g]));
    end

    always_comb begin
        aligned        = (bus_addr[1:0] == 2'b00);
        cand           = '0;
        cand[RG_DRX]   = ctl.dbg_en && hit_drx && !bus_write && bus_word && aligned;
        cand[RG_DTX]   = ctl.dbg_en && hit_dtx &&  bus_write && bus_word && aligned;
        cand[RG_EEP]   = ctl.eep_par_en && hit_eep;
        cand[RG_SDRAM] = ctl.sdram_en && hit_sd;
        cand[RG_FLASH] = ctl.flash_en && (ctl.sdram_en ? hit_fl[1] : hit_fl[0]);
    end

    // the highest index wins
    always_comb begin
        region_sel = '0;
        found      = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (bus_valid && cand[i] && !found) begin
                region_sel[i] = 1'b1;
                found         = 1'b1;
            end
        end
        unmapped = bus_valid && !found;
    end

    // R10: exactly one outcome per valid access, none otherwise
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones({unmapped, region_sel}) == 1));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (region_sel == '0 && !unmapped));

    // R8: the TX FIFO only takes aligned word writes while debug is on
    a_r8_tx_rules: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_DTX] |-> (bus_write && bus_word && bus_addr[1:0] == 2'b00 && ctl.dbg_en));

    // R9: the RX FIFO only serves aligned word reads while debug is on
    a_r9_rx_rules: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_DRX] |-> (!bus_write && bus_word && bus_addr[1:0] == 2'b00 && ctl.dbg_en));

    // R7: the EEPROM window needs its enable bit
    a_r7_eep_gated: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_EEP] |-> ctl.eep_par_en);

    // R5: the SDRAM window needs its enable bit
    a_r5_sdram_gated: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_SDRAM] |-> ctl.sdram_en);

endmodule

// File: rtl/cart_map_top.sv
module cart_map_top
    import cart_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SDRAM_LOG2 = 26,
    parameter int FLASH_LOG2 = 24,
    parameter int EEP_LOG2   = 11,
    parameter int FIFO_LOG2  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              console_evt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   region_sel,
    output logic              unmapped,
    output logic              eep_serial_en,
    output logic              eep_id16k
);

    localparam int PAD_W = DATA_W - CTL_W;

    cart_ctl_t  ctl;
    logic [PAD_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = reg_wdata[DATA_W-1:CTL_W];

    cart_ctrl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_wbits  (reg_wdata[CTL_W-1:0]),
        .console_evt(console_evt),
        .ctl        (ctl)
    );

    cart_decode #(
        .ADDR_W    (ADDR_W),
        .SDRAM_LOG2(SDRAM_LOG2),
        .FLASH_LOG2(FLASH_LOG2),
        .EEP_LOG2  (EEP_LOG2),
        .FIFO_LOG2 (FIFO_LOG2)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .region_sel(region_sel),
        .unmapped  (unmapped)
    );

    always_comb begin
        reg_rdata     = {{PAD_W{1'b0}}, ctl};
        eep_serial_en = ctl.eep_ser_en;
        eep_id16k     = ctl.eep_big;
    end

    // R12: EEPROM side outputs follow the stored register
    a_r12_eep_outs: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_serial_en == reg_rdata[3]) && (eep_id16k == reg_rdata[4]));

endmodule

// File: tb/sim_cart_map_top.sv
module sim_cart_map_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic        console_evt;
    logic        bus_valid, bus_write, bus_word;
    logic [31:0] bus_addr;

    logic [31:0] rd0, rd1;
    logic [4:0]  sel0, sel1;
    logic        um0, um1, ser0, ser1, id0, id1;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    cart_map_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd0),
        .console_evt(console_evt), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .region_sel(sel0), .unmapped(um0),
        .eep_serial_en(ser0), .eep_id16k(id0)
    );

    // wide SDRAM window so that it overlaps the moved flash window (R11)
    cart_map_top #(.SDRAM_LOG2(28)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd1),
        .console_evt(console_evt), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .region_sel(sel1), .unmapped(um1),
        .eep_serial_en(ser1), .eep_id16k(id1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns {unmapped, region_sel}
    function automatic logic [5:0] model(input logic [5:0] c, input logic v, input logic w,
                                         input logic wd, input logic [31:0] a, input int sdl);
        logic [63:0] ua;
        logic [63:0] fb;
        logic [4:0]  s;
        ua = {32'h0, a};
        fb = c[1] ? 64'h1800_0000 : 64'h1000_0000;
        s  = '0;
        if (!v) return 6'b0;
        if (c[5] && !w && wd && a[1:0] == 2'b00 && ua >= 64'h1D10_0000 && ua < 64'h1D10_0400)
            s[4] = 1'b1;
        else if (c[5] && w && wd && a[1:0] == 2'b00 && ua >= 64'h1D10_0800 && ua < 64'h1D10_0C00)
            s[3] = 1'b1;
        else if (c[2] && ua >= 64'h1D00_0000 && ua < 64'h1D00_0800)
            s[2] = 1'b1;
        else if (c[1] && ua >= 64'h1000_0000 && ua < 64'h1000_0000 + (64'd1 << sdl))
            s[1] = 1'b1;
        else if (c[0] && ua >= fb && ua < fb + 64'h0100_0000)
            s[0] = 1'b1;
        return (s == 5'b0) ? 6'b100000 : {1'b0, s};
    endfunction

    function automatic string tag_of(input logic [5:0] e);
        if (e[5]) return "R10 unmapped";
        if (e[4]) return "R9 rx";
        if (e[3]) return "R8 tx";
        if (e[2]) return "R7 eeprom";
        if (e[1]) return "R5 sdram";
        return "R6 flash";
    endfunction

    function automatic logic [31:0] probe_addr(input int bi, input int oi);
        logic [31:0] b, o;
        case (bi)
            0: b = 32'h1000_0000;
            1: b = 32'h1100_0000;
            2: b = 32'h1400_0000;
            3: b = 32'h1800_0000;
            4: b = 32'h1900_0000;
            5: b = 32'h1D00_0000;
            6: b = 32'h1D10_0000;
            7: b = 32'h1D10_0800;
            default: b = 32'h2000_0000;
        endcase
        case (oi)
            0: o = 32'hFFFF_FFFC;
            1: o = 32'h0;
            2: o = 32'h2;
            3: o = 32'h3FC;
            4: o = 32'h400;
            5: o = 32'h7FC;
            default: o = 32'h800;
        endcase
        return b + o;
    endfunction

    task automatic wr_ctl(input logic [5:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = 32'hA5A5_A5C0 | {26'h0, v};
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic chk_ctl(input string tag, input logic [5:0] v);
        chk(tag, rd0, {26'h0, v});
        chk(tag, rd1, {26'h0, v});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired during R1..R12 run, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [5:0] e0, e1;
        rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; console_evt = 1'b0;
        bus_valid = 1'b0; bus_write = 1'b0; bus_word = 1'b0; bus_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value, flash decoded at its low base
        chk_ctl("R1 reset value", 6'h01);
        chk("R12 reset eeprom outs", {30'h0, id0, ser0}, 32'h0);
        bus_valid = 1'b1; bus_word = 1'b1; bus_addr = 32'h1000_0100;
        #2;
        chk("R1 reset flash decode", {26'h0, um0, sel0}, 32'h01);

        // sweep every control value over window edges and access kinds
        for (int c = 0; c < 64; c++) begin
            wr_ctl(c[5:0]);
            chk_ctl("R2 write lands", c[5:0]);
            chk("R1 upper zero", rd0 & 32'hFFFF_FFC0, 32'h0);
            chk("R12 eeprom outs", {30'h0, id0, ser0}, {30'h0, c[4], c[3]});
            @(negedge clk);
            bus_valid = 1'b0; bus_write = 1'b1; bus_word = 1'b1; bus_addr = 32'h1D10_0800;
            #2;
            chk("R10 idle quiet", {26'h0, um0, sel0}, 32'h0);
            for (int bi = 0; bi < 9; bi++) begin
                for (int oi = 0; oi < 7; oi++) begin
                    for (int acc = 0; acc < 4; acc++) begin
                        @(negedge clk);
                        bus_valid = 1'b1;
                        bus_write = acc[0];
                        bus_word  = acc[1];
                        bus_addr  = probe_addr(bi, oi);
                        #2;
                        e0 = model(c[5:0], 1'b1, acc[0], acc[1], bus_addr, 26);
                        e1 = model(c[5:0], 1'b1, acc[0], acc[1], bus_addr, 28);
                        chk(tag_of(e0), {26'h0, um0, sel0}, {26'h0, e0});
                        chk("R11 priority wide sdram", {26'h0, um1, sel1}, {26'h0, e1});
                    end
                end
            end
        end

        // R11: moved flash base overlapped by the wide SDRAM window
        @(negedge clk);
        bus_valid = 1'b0;
        wr_ctl(6'h03);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = 1'b1; bus_addr = 32'h1800_0000;
        #2;
        chk("R11 sdram over flash", {26'h0, um1, sel1}, 32'h02);
        chk("R6 flash moved", {26'h0, um0, sel0}, 32'h01);

        // R3: event entry
        wr_ctl(6'h3E);
        @(negedge clk);
        console_evt = 1'b1;
        @(negedge clk);
        chk_ctl("R3 event entry", 6'h39);
        #2;
        chk("R3 flash back at low base", {26'h0, um0, sel0}, 32'h20);

        // R4: held, lower bits locked, upper bits writable
        wr_ctl(6'h06);
        chk_ctl("R4 held write locked", 6'h01);
        wr_ctl(6'h3E);
        chk_ctl("R4 held upper writable", 6'h39);

        // R4: write on the release edge still locked
        @(negedge clk);
        console_evt = 1'b0;
        reg_we = 1'b1; reg_wdata = 32'h0000_0006;
        @(negedge clk);
        reg_we = 1'b0;
        chk_ctl("R4 release edge locked", 6'h01);
        wr_ctl(6'h06);
        chk_ctl("R4 after release writable", 6'h06);

        // R3: write coinciding with event entry
        @(negedge clk);
        console_evt = 1'b1;
        reg_we = 1'b1; reg_wdata = 32'h0000_0036;
        @(negedge clk);
        reg_we = 1'b0;
        chk_ctl("R3 entry beats write", 6'h31);
        console_evt = 1'b0;
        repeat (2) @(negedge clk);
        wr_ctl(6'h02);
        chk_ctl("R2 write after event", 6'h02);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule